// File: doc/BRIEF.md
# Descriptor Chain Sequencer

This block is the control engine of one DMA channel. It walks a linked list of 16-byte descriptors held in memory. For each descriptor it reads the entry, decodes it and carries out one of three kinds of work. An input or output command hands a buffer to an external device through a start/done handshake. A short load or store moves one to four bytes between memory and the descriptor's dependency field. The remaining commands are a no-op and a stop.

When a descriptor finishes, the block writes the transfer status back into it, together with the residual count for data transfers. It then either falls through to the next entry or branches to the address held in the dependency field. The choices to wait, interrupt and branch come from an external condition evaluator, which looks at the current command word.

Descriptors are little-endian 32-bit words:
- word 0 holds the request count in bits 15:0 and the command in bits 31:16;
- word 1 holds the data address;
- word 2 holds the dependency value;
- word 3 holds the residual in bits 15:0 and the status in bits 31:16.

Command bits 15:12 are the opcode and bits 10:8 are the key. Bits 7:0 belong to the evaluator.

Top module: `dbd_sequencer`

## Requirements
- R1: After a synchronous active-low reset the channel is not active, not dead, the branch-taken flag is clear, and irq, mem_req and xfer_start are low.
- R2: The channel starts when wake is pulsed while run is high and the channel is not dead. It then reads the first three descriptor words at the pointer, +4 and +8. Each memory request is held with a stable address until it is acknowledged.
- R3: Opcodes 0 and 1 (output) and 2 and 3 (input, with odd meaning last) give a one-cycle xfer_start. With it come the data address, the request count as length, the direction (output high) and the last flag.
- R4: On completion the status is written to pointer+12 with halfword {bt, dead, active, run} in bits 3:0. Input and output write all four bytes, with the device residual in the low half. Every other command writes only the upper two bytes.
- R5: Falling through adds 16 to the pointer and clears the branch flag. A taken branch loads the dependency value with its low four bits cleared, and sets the flag.
- R6: Any of these kills the channel: key 4 on any command; an input or output with key above 3 or a zero address; a load or store whose key is not 6; an opcode above 7. A kill sets dead, clears active, pulses irq and starts no transfer. While dead, wake has no effect.
- R7: Load (opcode 5) and store (opcode 4) pick their size from count bits 2:0. Bit 2 set gives 4 bytes; otherwise bit 1 set gives 2 bytes; otherwise 1 byte. A load merges the read bytes into the low bytes of the dependency field and stores that field back at pointer+8. A store writes the dependency field to the data address.
- R8: A stop (opcode 7) clears active and leaves the pointer where it is, with no write-back.
- R9: A software pointer write is accepted only while the channel is neither active nor mid-descriptor, and is forced to a 16-byte boundary.
- R10: The next descriptor is fetched only while both run and active are high. Lowering run clears active and dead, and the current descriptor still completes.
- R11: While the evaluator's wait input is high at completion, nothing is written back and the pointer does not move.
- R12: irq pulses for one cycle at the end of a descriptor when the evaluator's interrupt input is high.
- R13: Load and store never branch, whatever the evaluator's branch input says.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_i | input | 1 | Software run level |
| wake_i | input | 1 | Software wake pulse (activates the channel) |
| ptr_we_i | input | 1 | Software pointer write strobe |
| ptr_wdata_i | input | 32 | Software pointer value |
| ev_cmd_o | output | 16 | Current command word, to the evaluator |
| ev_wait_i | input | 1 | Evaluator: hold at completion |
| ev_irq_i | input | 1 | Evaluator: interrupt at completion |
| ev_branch_i | input | 1 | Evaluator: take the branch |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 32 | Memory byte address |
| mem_be_o | output | 4 | Byte enables |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| xfer_start_o | output | 1 | Device transfer start pulse |
| xfer_out_o | output | 1 | Transfer direction, high for output |
| xfer_last_o | output | 1 | Last buffer of a packet |
| xfer_addr_o | output | 32 | Buffer address |
| xfer_len_o | output | 16 | Requested length |
| xfer_done_i | input | 1 | Device completion pulse |
| xfer_resid_i | input | 16 | Remaining length, valid with done |
| irq_o | output | 1 | Interrupt pulse |
| active_o | output | 1 | Channel active |
| dead_o | output | 1 | Channel killed |
| bt_o | output | 1 | Last step was a branch |
| ptr_o | output | 32 | Command pointer |

## Verification
Some properties are checked on every cycle:
- a held memory request keeps its address;
- the start pulse lasts one cycle;
- the pointer is frozen while active except at the advance step;
- a kill forces dead;
- a stop clears active;
- load and store leave the branch flag clear;
- the wait input stalls completion.

The bench scenarios are what show the values that reach memory. These are the written-back status and residual words, the merged load bytes for every count encoding, and the pointer after branches and stops. The scenarios also cover the whole key sweep, and show that a pointer write or a wake made at the wrong moment leaves no trace.

// File: rtl/dbd_pkg.sv
// Package: shared types for the descriptor chain sequencer.
// Assumes 32-bit little-endian descriptor words.
package dbd_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_FETCH, S_DECODE, S_XSTART, S_XWAIT,
        S_WORD, S_COMPL, S_WBDEP, S_WBST, S_ADV
    } seq_state_t;

    typedef struct packed {
        logic       io;     // input or output transfer
        logic       out;    // direction: output
        logic       last;   // last buffer flag
        logic       word;   // short load or store
        logic       load;   // load (else store) when word
        logic       stop;   // stop command
        logic       bad;    // command kills the channel
        logic [3:0] wmask;  // byte mask for load/store
    } dec_t;

endpackage

// File: rtl/dbd_decode.sv
// Module: dbd_decode
// Purely combinational decode of a fetched descriptor into action flags.
// Assumes opcode in cmd[15:12] and key in cmd[10:8]; cmd[7:0] is not used here.
module dbd_decode
    import dbd_pkg::*;
#(
    parameter int AW         = 32,
    parameter int STREAM_MAX = 3,
    parameter int SYS_KEY    = 6,
    parameter int BAD_KEY    = 4
) (
    input  logic [15:0]   cmd_i,
    input  logic [15:0]   cnt_i,
    input  logic [AW-1:0] addr_i,
    output dec_t          dec_o
);
    logic [3:0] op;
    logic [2:0] key;

    assign op  = cmd_i[15:12];
    assign key = cmd_i[10:8];

    // Classify the opcode and apply the key and address validity rules.
    always_comb begin
        dec_o       = '0;
        dec_o.wmask = cnt_i[2] ? 4'hF : (cnt_i[1] ? 4'h3 : 4'h1);
        unique case (op)
            4'd0, 4'd1, 4'd2, 4'd3: begin
                dec_o.io   = 1'b1;
                dec_o.out  = ~op[1];
                dec_o.last = op[0];
                dec_o.bad  = (int'(key) == BAD_KEY) || (int'(key) > STREAM_MAX)
                             || (addr_i == '0);
            end
            4'd4, 4'd5: begin
                dec_o.word = 1'b1;
                dec_o.load = op[0];
                dec_o.bad  = (int'(key) != SYS_KEY);
            end
            4'd6: dec_o.bad = (int'(key) == BAD_KEY);
            4'd7: begin
                dec_o.stop = 1'b1;
                dec_o.bad  = (int'(key) == BAD_KEY);
            end
            default: dec_o.bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/dbd_status.sv
// Module: dbd_status
// Holds the channel flags active, dead and branch-taken.
// Assumes kill and stop come from the sequencer as single-cycle strobes.
module dbd_status (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic wake_i,
    input  logic kill_i,
    input  logic stop_i,
    input  logic bt_set_i,
    input  logic bt_clr_i,
    output logic active_o,
    output logic dead_o,
    output logic bt_o
);
    // Active: dropped by kill, stop or run low; raised by a wake while running.
    always_ff @(posedge clk) begin
        if (!rst_n)                            active_o <= 1'b0;
        else if (kill_i || stop_i || !run_i)   active_o <= 1'b0;
        else if (wake_i && !dead_o)            active_o <= 1'b1;
    end

    // Dead: set by a kill, cleared only when software lowers run.
    always_ff @(posedge clk) begin
        if (!rst_n)       dead_o <= 1'b0;
        else if (kill_i)  dead_o <= 1'b1;
        else if (!run_i)  dead_o <= 1'b0;
    end

    // Branch-taken flag: follows the last pointer advance.
    always_ff @(posedge clk) begin
        if (!rst_n)         bt_o <= 1'b0;
        else if (bt_set_i)  bt_o <= 1'b1;
        else if (bt_clr_i)  bt_o <= 1'b0;
    end

    p_kill_dead_r6: assert property (@(posedge clk) disable iff (!rst_n)
        kill_i |=> (dead_o && !active_o));
    p_runlow_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !active_o);
    p_dead_blocks_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dead_o && !active_o) |=> !active_o);
endmodule

// File: rtl/dbd_sequencer.sv
// Module: dbd_sequencer (top)
// Fetches, executes and retires one descriptor at a time for one channel.
// Assumes a memory port that holds no more than one request and answers with a
// one-cycle ack, and a device that answers every start with one done pulse.
module dbd_sequencer
    import dbd_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DESC_BYTES = 16,
    parameter int STREAM_MAX = 3,
    parameter int SYS_KEY    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          wake_i,
    input  logic          ptr_we_i,
    input  logic [AW-1:0] ptr_wdata_i,
    output logic [15:0]   ev_cmd_o,
    input  logic          ev_wait_i,
    input  logic          ev_irq_i,
    input  logic          ev_branch_i,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [3:0]    mem_be_o,
    output logic [31:0]   mem_wdata_o,
    input  logic          mem_ack_i,
    input  logic [31:0]   mem_rdata_i,
    output logic          xfer_start_o,
    output logic          xfer_out_o,
    output logic          xfer_last_o,
    output logic [AW-1:0] xfer_addr_o,
    output logic [15:0]   xfer_len_o,
    input  logic          xfer_done_i,
    input  logic [15:0]   xfer_resid_i,
    output logic          irq_o,
    output logic          active_o,
    output logic          dead_o,
    output logic          bt_o,
    output logic [AW-1:0] ptr_o
);
    localparam int FETCH_WORDS = 3;
    localparam int WCW         = $clog2(FETCH_WORDS);
    localparam logic [AW-1:0] ALIGN_MASK = ~AW'(DESC_BYTES - 1);
    localparam logic [AW-1:0] DEP_OFS    = AW'(8);
    localparam logic [AW-1:0] STAT_OFS   = AW'(DESC_BYTES - 4);

    seq_state_t     state_q;
    logic [AW-1:0]  ptr_q;
    logic [WCW-1:0] wcnt_q;
    logic [31:0]    word_q [FETCH_WORDS];
    logic [15:0]    resid_q;
    logic           irq_q;
    dec_t           dec;
    logic           kill, stop, take_br, fetch_last;
    logic [31:0]    load_mask, merged;
    logic [15:0]    stat16;

    assign ev_cmd_o = word_q[0][31:16];

    dbd_decode #(.AW(AW), .STREAM_MAX(STREAM_MAX), .SYS_KEY(SYS_KEY), .BAD_KEY(4)) i_decode (
        .cmd_i (word_q[0][31:16]),
        .cnt_i (word_q[0][15:0]),
        .addr_i(word_q[1][AW-1:0]),
        .dec_o (dec)
    );

    assign kill    = (state_q == S_DECODE) && dec.bad;
    assign stop    = (state_q == S_DECODE) && dec.stop && !dec.bad;
    assign take_br = (state_q == S_ADV) && ev_branch_i && !dec.word;

    dbd_status i_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run_i),
        .wake_i  (wake_i),
        .kill_i  (kill),
        .stop_i  (stop),
        .bt_set_i(take_br),
        .bt_clr_i((state_q == S_ADV) && !take_br),
        .active_o(active_o),
        .dead_o  (dead_o),
        .bt_o    (bt_o)
    );

    // Byte-lane expansion of the load/store size mask.
    for (genvar b = 0; b < 4; b++) begin : g_lane
        assign load_mask[8*b +: 8] = {8{dec.wmask[b]}};
    end
    assign merged     = (word_q[2] & ~load_mask) | (mem_rdata_i & load_mask);
    assign stat16     = {12'h000, bt_o, dead_o, active_o, run_i};
    assign fetch_last = (wcnt_q == WCW'(FETCH_WORDS - 1));

    // Memory port: request attributes per state.
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = ptr_q + AW'({wcnt_q, 2'b00});
        mem_be_o    = 4'hF;
        mem_wdata_o = word_q[2];
        unique case (state_q)
            S_FETCH: mem_req_o = 1'b1;
            S_WORD: begin
                mem_req_o  = 1'b1;
                mem_we_o   = !dec.load;
                mem_addr_o = word_q[1][AW-1:0];
                mem_be_o   = dec.wmask;
            end
            S_WBDEP: begin
                mem_req_o  = 1'b1;
                mem_we_o   = 1'b1;
                mem_addr_o = ptr_q + DEP_OFS;
            end
            S_WBST: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = ptr_q + STAT_OFS;
                mem_be_o    = dec.io ? 4'hF : 4'hC;
                mem_wdata_o = {stat16, dec.io ? resid_q : 16'h0000};
            end
            default: ;
        endcase
    end

    // Device handshake outputs.
    assign xfer_start_o = (state_q == S_XSTART);
    assign xfer_out_o   = dec.out;
    assign xfer_last_o  = dec.last;
    assign xfer_addr_o  = word_q[1][AW-1:0];
    assign xfer_len_o   = word_q[0][15:0];
    assign irq_o        = irq_q;
    assign ptr_o        = ptr_q;

    // Sequencer: fetch, execute, complete, write back, advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            ptr_q   <= '0;
            wcnt_q  <= '0;
            resid_q <= '0;
            irq_q   <= 1'b0;
            for (int i = 0; i < FETCH_WORDS; i++) word_q[i] <= '0;
        end else begin
            irq_q <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    wcnt_q <= '0;
                    if (ptr_we_i && !active_o) ptr_q <= ptr_wdata_i & ALIGN_MASK;
                    else if (active_o && run_i) state_q <= S_FETCH;
                end
                S_FETCH: if (mem_ack_i) begin
                    word_q[wcnt_q] <= mem_rdata_i;
                    wcnt_q         <= wcnt_q + 1'b1;
                    if (fetch_last) state_q <= S_DECODE;
                end
                S_DECODE: begin
                    if (dec.bad) begin
                        irq_q   <= 1'b1;
                        state_q <= S_IDLE;
                    end else if (dec.stop) state_q <= S_IDLE;
                    else if (dec.io)       state_q <= S_XSTART;
                    else if (dec.word)     state_q <= S_WORD;
                    else                   state_q <= S_COMPL;
                end
                S_XSTART: state_q <= S_XWAIT;
                S_XWAIT: if (xfer_done_i) begin
                    resid_q <= xfer_resid_i;
                    state_q <= S_COMPL;
                end
                S_WORD: if (mem_ack_i) begin
                    if (dec.load) word_q[2] <= merged;
                    state_q <= S_COMPL;
                end
                S_COMPL: if (!ev_wait_i) state_q <= (dec.word && dec.load) ? S_WBDEP : S_WBST;
                S_WBDEP: if (mem_ack_i) state_q <= S_WBST;
                S_WBST:  if (mem_ack_i) state_q <= S_ADV;
                S_ADV: begin
                    irq_q   <= ev_irq_i;
                    ptr_q   <= take_br ? (word_q[2][AW-1:0] & ALIGN_MASK)
                                       : ptr_q + AW'(DESC_BYTES);
                    state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (state_q == S_IDLE && !irq_o && !mem_req_o && !xfer_start_o));
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));
    p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start_o |=> !xfer_start_o);
    p_fall_through_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ADV && !take_br) |=> (ptr_q == $past(ptr_q) + AW'(DESC_BYTES) && !bt_o));
    p_branch_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take_br |=> bt_o);
    p_stop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!active_o && $stable(ptr_q)));
    p_ptr_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && state_q != S_ADV) |=> $stable(ptr_q));
    p_wait_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_COMPL && ev_wait_i) |=> (state_q == S_COMPL && !mem_req_o));
    p_word_no_branch_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ADV && dec.word) |=> !bt_o);
endmodule

// File: tb/test_dbd_sequencer.sv
module test_dbd_sequencer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_i = 1'b0, wake_i = 1'b0, ptr_we_i = 1'b0;
    logic [31:0] ptr_wdata_i = '0;
    logic [15:0] ev_cmd_o;
    logic        ev_wait_i, ev_irq_i, ev_branch_i;
    logic        mem_req_o, mem_we_o, mem_ack_i = 1'b0;
    logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i = '0;
    logic [3:0]  mem_be_o;
    logic        xfer_start_o, xfer_out_o, xfer_last_o, xfer_done_i = 1'b0;
    logic [31:0] xfer_addr_o;
    logic [15:0] xfer_len_o, xfer_resid_i = '0;
    logic        irq_o, active_o, dead_o, bt_o;
    logic [31:0] ptr_o;

    int nchk = 0, nerr = 0;
    logic hold_wait = 1'b0;
    int   dev_delay = 3;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bench evaluator: bit0 interrupt, bit1 branch, bit2 wait (gated by hold_wait).
    assign ev_irq_i    = ev_cmd_o[0];
    assign ev_branch_i = ev_cmd_o[1];
    assign ev_wait_i   = ev_cmd_o[2] & hold_wait;

    dbd_sequencer i_dbd_sequencer (.*);

    // Memory model: 128 words, one-cycle ack, byte enables; plus a bench loader.
    logic [31:0] mem [128];
    logic        ld_en = 1'b0;
    logic [6:0]  ld_idx = '0;
    logic [31:0] ld_val = '0;
    always @(posedge clk) begin
        if (ld_en) mem[ld_idx] <= ld_val;
        if (mem_req_o && !mem_ack_i) begin
            mem_ack_i <= 1'b1;
            if (mem_we_o) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be_o[b]) mem[mem_addr_o[8:2]][8*b +: 8] <= mem_wdata_o[8*b +: 8];
            end else mem_rdata_i <= mem[mem_addr_o[8:2]];
        end else mem_ack_i <= 1'b0;
    end

    // Device model: logs each start, answers with residual = length/2.
    int          nx = 0, nirq = 0, dcnt = 0;
    logic        dbusy = 1'b0;
    logic [15:0] dlen = '0;
    logic        lg_out [32];
    logic        lg_last [32];
    logic [31:0] lg_addr [32];
    logic [15:0] lg_len [32];
    always @(posedge clk) begin
        xfer_done_i <= 1'b0;
        if (irq_o) nirq <= nirq + 1;
        if (xfer_start_o) begin
            lg_out[nx % 32]  <= xfer_out_o;
            lg_last[nx % 32] <= xfer_last_o;
            lg_addr[nx % 32] <= xfer_addr_o;
            lg_len[nx % 32]  <= xfer_len_o;
            nx    <= nx + 1;
            dbusy <= 1'b1;
            dcnt  <= dev_delay;
            dlen  <= xfer_len_o;
        end else if (dbusy) begin
            if (dcnt == 0) begin
                xfer_done_i  <= 1'b1;
                xfer_resid_i <= dlen >> 1;
                dbusy        <= 1'b0;
            end else dcnt <= dcnt - 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic ld(input logic [8:0] a, input logic [31:0] v);
        @(negedge clk); ld_en = 1'b1; ld_idx = a[8:2]; ld_val = v;
        @(negedge clk); ld_en = 1'b0;
    endtask

    task automatic desc(input logic [8:0] a, input logic [31:0] w0, input logic [31:0] w1,
                        input logic [31:0] w2, input logic [31:0] w3);
        ld(a, w0); ld(a + 9'd4, w1); ld(a + 9'd8, w2); ld(a + 9'd12, w3);
    endtask

    task automatic ptrw(input logic [31:0] v);
        @(negedge clk); ptr_we_i = 1'b1; ptr_wdata_i = v;
        @(negedge clk); ptr_we_i = 1'b0;
    endtask

    task automatic wake();
        @(negedge clk); wake_i = 1'b1;
        @(negedge clk); wake_i = 1'b0;
    endtask

    task automatic settle();
        for (int i = 0; i < 3000 && active_o; i++) @(negedge clk);
        repeat (12) @(negedge clk);
    endtask

    task automatic run_cycle();
        @(negedge clk); run_i = 1'b0;
        @(negedge clk); run_i = 1'b1;
    endtask

    function automatic logic [31:0] wmask(input logic [2:0] c);
        return c[2] ? 32'hFFFF_FFFF : (c[1] ? 32'h0000_FFFF : 32'h0000_00FF);
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nchk++; nerr++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int x0, i0;
        for (int i = 0; i < 128; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!active_o && !dead_o && !bt_o && !irq_o && !mem_req_o && !xfer_start_o,
            "R1 reset state", {26'h0, active_o, dead_o, bt_o, irq_o, mem_req_o, xfer_start_o}, 32'h0);
        @(negedge clk); rst_n = 1'b1;

        // Scenario A: a chain with output, input, branching no-op, store, load, stop.
        desc(9'h040, 32'h0000_0020, 32'h80, 32'h0, 32'h0);
        desc(9'h050, 32'h3101_0008, 32'h90, 32'h0, 32'h0);
        desc(9'h060, 32'h6002_0000, 32'h0, 32'hC0, 32'h0000_5555);
        desc(9'h0C0, 32'h4602_0002, 32'hF0, 32'h0000_ABCD, 32'h0);
        desc(9'h0D0, 32'h5601_0001, 32'hF4, 32'hAAAA_AA00, 32'h0);
        desc(9'h0E0, 32'h7000_0000, 32'h0, 32'h0, 32'h7777_7777);
        ld(9'h0F0, 32'hFFFF_FFFF); ld(9'h0F4, 32'h1234_5678);
        @(negedge clk); run_i = 1'b1;
        x0 = nx; i0 = nirq;
        ptrw(32'h40); wake(); settle();
        chk(nx == x0 + 2, "R3 transfer count", nx, x0 + 2);
        chk(lg_out[x0 % 32] && !lg_last[x0 % 32] && lg_addr[x0 % 32] == 32'h80 && lg_len[x0 % 32] == 16'h20,
            "R3 output-more fields", lg_addr[x0 % 32], 32'h80);
        chk(!lg_out[(x0+1) % 32] && lg_last[(x0+1) % 32] && lg_addr[(x0+1) % 32] == 32'h90 && lg_len[(x0+1) % 32] == 16'h8,
            "R3 input-last fields", lg_addr[(x0+1) % 32], 32'h90);
        chk(mem[8'h4C >> 2] == 32'h0003_0010, "R4 output write-back", mem[8'h4C >> 2], 32'h0003_0010);
        chk(mem[8'h5C >> 2] == 32'h0003_0004, "R4 input write-back", mem[8'h5C >> 2], 32'h0003_0004);
        chk(mem[8'h6C >> 2] == 32'h0003_5555, "R4 no-op status only", mem[8'h6C >> 2], 32'h0003_5555);
        chk(mem[8'hCC >> 2] == 32'h000B_0000, "R5 branch flag in status", mem[8'hCC >> 2], 32'h000B_0000);
        chk(mem[8'hF0 >> 2] == 32'hFFFF_ABCD, "R7 two-byte store", mem[8'hF0 >> 2], 32'hFFFF_ABCD);
        chk(mem[8'hD8 >> 2] == 32'hAAAA_AA78, "R7 one-byte load", mem[8'hD8 >> 2], 32'hAAAA_AA78);
        chk(mem[8'hDC >> 2] == 32'h0003_0000, "R13 load fell through, bt clear", mem[8'hDC >> 2], 32'h0003_0000);
        chk(ptr_o == 32'hE0 && !active_o && !bt_o, "R8 stop keeps pointer", ptr_o, 32'hE0);
        chk(mem[8'hEC >> 2] == 32'h7777_7777, "R8 stop writes nothing", mem[8'hEC >> 2], 32'h7777_7777);
        chk(nirq == i0 + 2, "R12 interrupt count", nirq, i0 + 2);

        // Scenario B: alignment, bad key, dead blocks wake, zero address.
        desc(9'h100, 32'h0500_0004, 32'h80, 32'h0, 32'h0);
        desc(9'h110, 32'h0000_0004, 32'h0, 32'h0, 32'h0);
        x0 = nx; i0 = nirq;
        ptrw(32'h105);
        chk(ptr_o == 32'h100, "R9 aligned pointer write", ptr_o, 32'h100);
        wake(); settle();
        chk(dead_o && !active_o && nx == x0, "R6 key 5 kills", {dead_o, active_o}, 32'h2);
        chk(nirq == i0 + 1, "R6 kill interrupt", nirq, i0 + 1);
        wake(); repeat (4) @(negedge clk);
        chk(!active_o, "R6 wake ignored while dead", active_o, 0);
        @(negedge clk); run_i = 1'b0; @(negedge clk);
        chk(!dead_o, "R10 run low clears dead", dead_o, 0);
        run_i = 1'b1;
        ptrw(32'h110); wake(); settle();
        chk(dead_o && nx == x0, "R6 zero address kills", dead_o, 1);
        run_cycle();

        // Scenario C: wait hold, pointer write while active, run dropped mid-descriptor.
        desc(9'h180, 32'h1204_0010, 32'h80, 32'h0, 32'h9999_9999);
        desc(9'h190, 32'h0000_0004, 32'h84, 32'h0, 32'h0);
        dev_delay = 20; hold_wait = 1'b1; x0 = nx;
        ptrw(32'h180); wake();
        repeat (5) @(negedge clk);
        ptrw(32'h1F0);
        repeat (60) @(negedge clk);
        chk(mem[9'h18C >> 2] == 32'h9999_9999, "R11 no write-back while waiting", mem[9'h18C >> 2], 32'h9999_9999);
        chk(ptr_o == 32'h180, "R9 write ignored while active", ptr_o, 32'h180);
        @(negedge clk); run_i = 1'b0;
        repeat (2) @(negedge clk); hold_wait = 1'b0;
        repeat (20) @(negedge clk);
        chk(mem[9'h18C >> 2] == 32'h0000_0008, "R10 completes with run low", mem[9'h18C >> 2], 32'h0000_0008);
        chk(ptr_o == 32'h190 && nx == x0 + 1, "R10 no further fetch", ptr_o, 32'h190);
        chk(lg_out[x0 % 32] && lg_last[x0 % 32], "R3 output-last flags", {lg_out[x0 % 32], lg_last[x0 % 32]}, 32'h3);
        @(negedge clk); run_i = 1'b1; dev_delay = 3;

        // Scenario D: key sweep on an output command.
        for (int k = 0; k < 8; k++) begin
            run_cycle();
            desc(9'h1C0, {16'h0000 | (16'(k) << 8), 16'h0004}, 32'h80, 32'h0, 32'h0);
            desc(9'h1D0, 32'h7000_0000, 32'h0, 32'h0, 32'h0);
            x0 = nx;
            ptrw(32'h1C0); wake(); settle();
            if (k < 4) chk(!dead_o && nx == x0 + 1 && ptr_o == 32'h1D0, "R6 valid stream key runs", ptr_o, 32'h1D0);
            else       chk(dead_o && nx == x0 && ptr_o == 32'h1C0, "R6 out-of-range key kills", ptr_o, 32'h1C0);
        end

        // Scenario E: load size sweep over all count encodings.
        ld(9'h1E0, 32'h89AB_CDEF);
        for (int c = 0; c < 8; c++) begin
            logic [31:0] m, e;
            run_cycle();
            desc(9'h1C0, 32'h5600_0000 | 32'(c), 32'h1E0, 32'h1111_1111, 32'h0);
            m = wmask(3'(c));
            e = (32'h1111_1111 & ~m) | (32'h89AB_CDEF & m);
            ptrw(32'h1C0); wake(); settle();
            chk(mem[9'h1C8 >> 2] == e, "R7 load size by count", mem[9'h1C8 >> 2], e);
            chk(mem[9'h1CC >> 2] == 32'h0003_0000 && ptr_o == 32'h1D0, "R4 load status write-back",
                mem[9'h1CC >> 2], 32'h0003_0000);
        end

        finish_run();
    end
endmodule